// File: doc/BRIEF.md
# Six-Counter Performance Monitor

This block is a bank of six 32-bit event counters for a processor core. It watches two things: how many instructions retired in each clock, given as a small batch count, and the passing of clock cycles. Counters 1 to 4 pick what they count from an 8-bit event code each. Counter 5 always counts retired instructions and counter 6 always counts cycles. A control register holds three freeze bits and two overflow-enable bits. A small write/read port loads the counters and both control registers and reads them back.

The block turns the control registers into two registered summary masks. The first says which counters count instructions and the second says which count cycles. The counters advance from these masks. Counter 4 has one extra event: it counts retired instructions only while the run-latch input is high. When a counter with overflow enabled reaches the sign-bit threshold, it is pinned at that threshold and a one-clock overflow pulse goes out.

Top module: `perf_counter_bank`

## Requirements
- R1: Synchronous active-high reset clears all six counters, the select register, the masks, `ovf_pulse` and `rd_data`, and sets the control register to 0x01, so everything starts frozen.
- R2: Control bit 0 (global freeze) stops all six counters and forces both masks to zero.
- R3: Control bit 1 stops counters 1 to 4 and control bit 2 stops counters 5 and 6. The masks clear the bits of the frozen counters.
- R4: Counter k (k = 1..4) reads its event code from select bits [8k-1:8k-8]. Counter 1 counts instructions for codes 0x02 and 0xFE and cycles for codes 0x1E and 0xF0.
- R5: Counters 2 to 4 count instructions for code 0x02 and cycles for code 0x1E. Counter 4 also treats 0xFA as an instruction event. Any other code leaves the counter idle, and a select register of all zeros idles counters 1 to 4.
- R6: Unless frozen, counter 5 counts instructions and counter 6 counts cycles. Mask bit i belongs to counter i+1, and no counter is in both masks.
- R7: On each clock edge, an instruction counter adds `retire_cnt` in one step and a cycle counter adds 1. A `retire_cnt` of 0 changes nothing.
- R8: With code 0xFA, counter 4 adds `retire_cnt` only in cycles where `run_latch` is high.
- R9: If a counter's new value has bit 31 set and its overflow enable is on, the counter is set to exactly 0x80000000. `ovf_pulse` is then high in the next cycle, as the OR over all counters. Counter 1 uses control bit 3 as its enable; counters 2 to 6 share control bit 4.
- R10: With overflow disabled, a counter keeps counting past 0x80000000 and wraps modulo 2^32.
- R11: A write to the control register (address 6) or the select register (address 7) updates both masks on the same clock edge.
- R12: Addresses 0 to 5 are counters 1 to 6. A write to a counter overrides its increment in that cycle. `rd_data` returns the addressed register one cycle after `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0-5 counters, 6 control, 7 select) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Registered read data |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| run_latch | input | 1 | Qualifier for the run-latch instruction event on counter 4 |
| inst_mask | output | 6 | Counters that count instructions |
| cyc_mask | output | 6 | Counters that count cycles |
| ovf_pulse | output | 1 | One-clock overflow indication |

## Verification
The bench tries all 256 event codes in each of the four select fields and all 32 control values, and compares both masks with codes computed from the requirements. A decoder that mixed up which code belongs to which counter would show up here, for example one that let counters 2 to 4 accept 0xFE, or one that ignored the all-zero select rule. Counting runs push counters across the threshold with each enable split, with a batch of zero, and with the run latch both low and high. A design that wrapped instead of clamping, shared the wrong enable bit, or let counter 4's run-latch event count freely would read back wrong values or produce the wrong number of overflow pulses. A counter write made during active counting must win over that cycle's increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CNT = 6;
  localparam int NUM_SEL = 4;
  localparam int SEL_W   = 8;
  localparam int SEL_TOT = NUM_SEL * SEL_W;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 3'd7;

  localparam logic [SEL_W-1:0] EV_INST     = 8'h02;
  localparam logic [SEL_W-1:0] EV_INST_ALT = 8'hFE;
  localparam logic [SEL_W-1:0] EV_INST_RUN = 8'hFA;
  localparam logic [SEL_W-1:0] EV_CYC      = 8'h1E;
  localparam logic [SEL_W-1:0] EV_CYC_ALT  = 8'hF0;

  // control register, bit 0 is the LSB field (last in the struct)
  typedef struct packed {
    logic ove_rest;   // bit 4: overflow enable, counters 2..6
    logic ove_first;  // bit 3: overflow enable, counter 1
    logic frz_hi;     // bit 2: freeze counters 5..6
    logic frz_lo;     // bit 1: freeze counters 1..4
    logic frz_all;    // bit 0: freeze everything
  } ctrl_t;

  localparam int    CTRL_W   = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = ctrl_t'(5'b00001);
endpackage

// File: rtl/pmu_event_decode.sv
module pmu_event_decode
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  ctrl_t              ctrl_nx,
  input  logic [SEL_TOT-1:0] sel_nx,
  output logic [NUM_CNT-1:0] inst_mask,
  output logic [NUM_CNT-1:0] cyc_mask
);
  logic [NUM_CNT-1:0] ins_d;
  logic [NUM_CNT-1:0] cyc_d;

  always_comb begin
    ins_d = '0;
    cyc_d = '0;
    if (!ctrl_nx.frz_all) begin
      if (!ctrl_nx.frz_lo && (|sel_nx)) begin
        for (int k = 0; k < NUM_SEL; k++) begin
          ins_d[k] = (sel_nx[k*SEL_W +: SEL_W] == EV_INST)
                  || ((k == 0) && (sel_nx[k*SEL_W +: SEL_W] == EV_INST_ALT))
                  || ((k == NUM_SEL-1) && (sel_nx[k*SEL_W +: SEL_W] == EV_INST_RUN));
          cyc_d[k] = (sel_nx[k*SEL_W +: SEL_W] == EV_CYC)
                  || ((k == 0) && (sel_nx[k*SEL_W +: SEL_W] == EV_CYC_ALT));
        end
      end
      if (!ctrl_nx.frz_hi) begin
        ins_d[NUM_SEL]   = 1'b1;
        cyc_d[NUM_SEL+1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inst_mask <= '0;
      cyc_mask  <= '0;
    end else if (load) begin
      inst_mask <= ins_d;
      cyc_mask  <= cyc_d;
    end
  end
endmodule

// File: rtl/pmu_lane.sv
module pmu_lane #(
  parameter int CNT_W = 32,
  parameter int AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AMT_W-1:0] amt,
  input  logic             ove,
  output logic [CNT_W-1:0] count,
  output logic             ovf_hit
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] sum;
  logic             active;

  assign active  = |amt;
  assign sum     = count + {{(CNT_W-AMT_W){1'b0}}, amt};
  assign ovf_hit = active && ove && sum[CNT_W-1] && !wr_hit;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (wr_hit)  count <= wr_data;
    else if (ovf_hit) count <= THRESH;
    else if (active)  count <= sum;
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int RET_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  input  logic [RET_W-1:0]   retire_cnt,
  input  logic               run_latch,
  output logic [NUM_CNT-1:0] inst_mask,
  output logic [NUM_CNT-1:0] cyc_mask,
  output logic               ovf_pulse
);
  localparam logic [RET_W-1:0] ONE = {{(RET_W-1){1'b0}}, 1'b1};

  ctrl_t              ctrl_q, ctrl_nx;
  logic [SEL_TOT-1:0] sel_q, sel_nx;
  logic               ctrl_wr, sel_wr, run_ok;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_CNT-1:0]            hit_vec;
  logic [CNT_W-1:0]              rd_nx;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign sel_wr  = wr_en && (wr_addr == ADDR_SEL);
  assign ctrl_nx = ctrl_wr ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
  assign sel_nx  = sel_wr ? wr_data[SEL_TOT-1:0] : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      sel_q  <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      sel_q  <= sel_nx;
    end
  end

  pmu_event_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .load      (ctrl_wr || sel_wr),
    .ctrl_nx   (ctrl_nx),
    .sel_nx    (sel_nx),
    .inst_mask (inst_mask),
    .cyc_mask  (cyc_mask)
  );

  assign run_ok = (sel_q[(NUM_SEL-1)*SEL_W +: SEL_W] != EV_INST_RUN) || run_latch;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
    logic             ins_on, ove_g, hit_g;
    logic [RET_W-1:0] amt_g;

    assign ins_on = inst_mask[g] && ((g != NUM_SEL-1) || run_ok);
    assign amt_g  = ins_on ? retire_cnt : (cyc_mask[g] ? ONE : '0);
    assign ove_g  = (g == 0) ? ctrl_q.ove_first : ctrl_q.ove_rest;
    assign hit_g  = wr_en && (int'(wr_addr) == g);

    pmu_lane #(.CNT_W(CNT_W), .AMT_W(RET_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (hit_g),
      .wr_data (wr_data),
      .amt     (amt_g),
      .ove     (ove_g),
      .count   (cnt_vec[g]),
      .ovf_hit (hit_vec[g])
    );
  end

  always_comb begin
    rd_nx = '0;
    if (rd_addr == ADDR_CTRL)     rd_nx = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
    else if (rd_addr == ADDR_SEL) rd_nx = {{(CNT_W-SEL_TOT){1'b0}}, sel_q};
    else begin
      for (int i = 0; i < NUM_CNT; i++)
        if (int'(rd_addr) == i) rd_nx = cnt_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      rd_data   <= rd_nx;
      ovf_pulse <= |hit_vec;
    end
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [CNT_W-1:0]              wr_data,
  input logic [CNT_W-1:0]              rd_data,
  input logic [NUM_CNT-1:0]            inst_mask,
  input logic [NUM_CNT-1:0]            cyc_mask,
  input logic                          ovf_pulse,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  logic             any_thr;
  logic             wq_v;
  logic [ADDR_W-1:0] wq_a;
  logic [CNT_W-1:0] wq_d;
  logic [CNT_W-1:0] wq_now;

  always_comb begin
    any_thr = 1'b0;
    wq_now  = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cnt_vec[i] == THRESH) any_thr = 1'b1;
      if (int'(wq_a) == i) wq_now = cnt_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wq_v <= 1'b0;
      wq_a <= '0;
      wq_d <= '0;
    end else begin
      wq_v <= wr_en && (int'(wr_addr) < NUM_CNT);
      wq_a <= wr_addr;
      wq_d <= wr_data;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ovf_pulse && rd_data == '0 && inst_mask == '0 && cyc_mask == '0)); // R1
  AST_GLOBAL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == ADDR_CTRL && wr_data[0]) |-> (inst_mask == '0 && cyc_mask == '0)); // R2
  AST_LOW_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == ADDR_CTRL && wr_data[1]) |-> (inst_mask[3:0] == '0 && cyc_mask[3:0] == '0)); // R3
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    (inst_mask & cyc_mask) == '0); // R6
  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> any_thr); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wq_v |-> (wq_now == wq_d)); // R12
endmodule

bind perf_counter_bank pmu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .inst_mask (inst_mask),
  .cyc_mask  (cyc_mask),
  .ovf_pulse (ovf_pulse),
  .cnt_vec   (cnt_vec)
);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  retire_cnt = '0;
  logic        run_latch = 1'b0;
  logic [5:0]  inst_mask, cyc_mask;
  logic        ovf_pulse;

  int total = 0;
  int bad = 0;
  int ovf_seen = 0;
  bit done = 0;
  logic [31:0] init_v [6];

  perf_counter_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .retire_cnt(retire_cnt),
    .run_latch(run_latch), .inst_mask(inst_mask), .cyc_mask(cyc_mask),
    .ovf_pulse(ovf_pulse)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (!rst && ovf_pulse) ovf_seen++;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = 3'(a);
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [5:0] e_ins(input logic [4:0] c, input logic [31:0] s);
    logic [5:0] e = '0;
    logic [7:0] b;
    if (!c[0]) begin
      if (!c[1] && s != 0)
        for (int k = 0; k < 4; k++) begin
          b = s[8*k +: 8];
          e[k] = (b == 8'h02) || (k == 0 && b == 8'hFE) || (k == 3 && b == 8'hFA);
        end
      if (!c[2]) e[4] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [5:0] e_cyc(input logic [4:0] c, input logic [31:0] s);
    logic [5:0] e = '0;
    logic [7:0] b;
    if (!c[0]) begin
      if (!c[1] && s != 0)
        for (int k = 0; k < 4; k++) begin
          b = s[8*k +: 8];
          e[k] = (b == 8'h1E) || (k == 0 && b == 8'hF0);
        end
      if (!c[2]) e[5] = 1'b1;
    end
    return e;
  endfunction

  task automatic run_case(input string tag, input logic [4:0] c, input logic [31:0] s,
                          input logic [3:0] r, input logic rl, input int n);
    logic [31:0] v [6];
    logic [31:0] got, amt;
    logic [5:0]  mi, mc;
    logic        flag, en;
    int          pulses;
    for (int i = 0; i < 6; i++) begin
      wr(i, init_v[i]);
      v[i] = init_v[i];
    end
    retire_cnt = r; run_latch = rl;
    wr(7, s);
    ovf_seen = 0;
    wr(6, {27'b0, c});
    repeat (n) idle();
    wr(6, 32'h1);
    idle();
    mi = e_ins(c, s); mc = e_cyc(c, s); pulses = 0;
    for (int e = 0; e <= n; e++) begin
      flag = 1'b0;
      for (int k = 0; k < 6; k++) begin
        if (mi[k]) amt = (k == 3 && s[31:24] == 8'hFA && !rl) ? 32'd0 : {28'b0, r};
        else       amt = mc[k] ? 32'd1 : 32'd0;
        if (amt != 0) begin
          v[k] = v[k] + amt;
          en = (k == 0) ? c[3] : c[4];
          if (v[k][31] && en) begin
            v[k] = 32'h8000_0000;
            flag = 1'b1;
          end
        end
      end
      if (flag) pulses++;
    end
    for (int k = 0; k < 6; k++) begin
      rd(k, got);
      check($sformatf("%s counter%0d", tag, k + 1), got, v[k]);
    end
    check($sformatf("%s R9 pulse count", tag), 32'(ovf_seen), 32'(pulses));
    retire_cnt = '0; run_latch = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 inst_mask", {26'b0, inst_mask}, 32'h0);
    check("R1 cyc_mask", {26'b0, cyc_mask}, 32'h0);
    check("R1 ovf_pulse", {31'b0, ovf_pulse}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(a, got);
      check($sformatf("R1 reg%0d", a), got, (a == 6) ? 32'h1 : 32'h0);
    end

    // R4 R5 R11: sweep every code in each select field
    wr(6, 32'h0);
    for (int k = 0; k < 4; k++)
      for (int code = 0; code < 256; code++) begin
        s = 32'(code) << (8 * k);
        wr(7, s);
        check($sformatf("%s ins k%0d code%0h", (k == 0) ? "R4" : "R5", k, code),
              {26'b0, inst_mask}, {26'b0, e_ins(5'h0, s)});
        check($sformatf("%s cyc k%0d code%0h", (k == 0) ? "R4" : "R5", k, code),
              {26'b0, cyc_mask}, {26'b0, e_cyc(5'h0, s)});
      end
    // R2 R3 R6 R11: sweep every control value
    wr(7, 32'hFA1E_02FE);
    for (int c = 0; c < 32; c++) begin
      wr(6, 32'(c));
      check($sformatf("R2/R3/R11 ins ctrl%0h", c), {26'b0, inst_mask}, {26'b0, e_ins(5'(c), 32'hFA1E_02FE)});
      check($sformatf("R2/R3/R6 cyc ctrl%0h", c), {26'b0, cyc_mask}, {26'b0, e_cyc(5'(c), 32'hFA1E_02FE)});
    end
    wr(6, 32'h0);
    wr(7, 32'h0);
    check("R5 zero select ins", {26'b0, inst_mask}, 32'h10);
    check("R5 zero select cyc", {26'b0, cyc_mask}, 32'h20);
    wr(6, 32'h1);

    for (int i = 0; i < 6; i++) init_v[i] = 32'h0;
    run_case("R7 basic", 5'h00, 32'h1E02_1E02, 4'd3, 1'b0, 9);
    for (int i = 0; i < 6; i++) init_v[i] = 32'd100;
    run_case("R8 run low", 5'h00, 32'hFA1E_02FE, 4'd5, 1'b0, 6);
    run_case("R8 run high", 5'h00, 32'hFA1E_02FE, 4'd5, 1'b1, 6);
    init_v[0] = 32'h7FFF_FFF0; init_v[1] = 32'h7FFF_FFFE; init_v[2] = 32'h7FFF_FFF0;
    init_v[3] = 32'h0;         init_v[4] = 32'h7FFF_FFFF; init_v[5] = 32'h7FFF_FFFC;
    run_case("R9 clamp", 5'h18, 32'h1E02_1E02, 4'd7, 1'b0, 5);
    for (int i = 0; i < 6; i++) init_v[i] = 32'h0;
    init_v[0] = 32'hFFFF_FFFE; init_v[4] = 32'h7FFF_FFFC; init_v[5] = 32'hFFFF_FFFF;
    run_case("R10 wrap", 5'h00, 32'h0000_0002, 4'd2, 1'b0, 4);
    init_v[0] = 32'h7FFF_FFFE; init_v[1] = 32'h7FFF_FFFE; init_v[4] = 32'h0; init_v[5] = 32'h0;
    run_case("R9 split enable", 5'h08, 32'h0000_1E02, 4'd1, 1'b0, 3);
    for (int i = 0; i < 6; i++) init_v[i] = 32'd5;
    run_case("R3 low frozen", 5'h02, 32'h1E02_1E02, 4'd2, 1'b0, 4);
    run_case("R3 high frozen", 5'h04, 32'h1E02_1E02, 4'd2, 1'b0, 4);
    run_case("R2 global frozen", 5'h19, 32'h1E02_1E02, 4'd3, 1'b0, 4);
    for (int i = 0; i < 6; i++) init_v[i] = 32'd9;
    run_case("R7 zero batch", 5'h00, 32'h0202_0202, 4'd0, 1'b0, 4);
    run_case("R5 idle codes", 5'h00, 32'hFEF0_FE1F, 4'd4, 1'b0, 3);

    // R12: counter write beats the increment in the same cycle
    wr(7, 32'h0);
    wr(6, 32'h0);
    repeat (3) idle();
    wr(5, 32'h100);
    wr(6, 32'h1);
    rd(5, got);
    check("R12 write priority counter6", got, 32'h101);
    rd(7, got);
    check("R12 select readback", got, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule